// File: doc/BRIEF.md
# Scanned Timer Table Engine

This block keeps a table of software timers in a small storage array and services all of them with one shared sequential engine. They are not separate counters. A programmable prescaler divides the clock into a tick. On every tick the engine visits each table entry once, one entry per clock. A live entry has its current count decremented. When the count expires the entry either reloads from its initial count (repeating timer) or is retired (one-shot timer). Each expiry sets that timer's bit in an event register. The event register has write-one-to-clear bits, and a mask turns it into a single interrupt line.

The host programs a timer through a single-cycle command. The command carries the timer index, the initial count, a repeat flag and an enable. A command never starts a scan. A command that arrives while the engine is busy is held in a one-deep holding register and written after the scan, before the next tick. While the holding register is full a busy flag is raised. A free-running 16-bit tick counter advances once per completed scan. An overrun flag records that a tick arrived while a scan was still running.

Top module: `tmr_table_top`

## Requirements
- R1: With `tick_period` = P (P >= 1), the prescaler issues a tick every P clocks. Each tick that finds the engine idle starts exactly one scan of the table. `tick_count` increases by exactly one after each completed scan. A scan of N entries occupies N+1 clocks after its tick.
- R2: An enabled entry programmed with initial count K (1 <= K < 2^CNT_W) expires on the K-th scan after it was written. The expiry sets bit `idx` of `events`. Several entries may expire in the same scan.
- R3: An expired entry with the repeat flag set reloads its current count from the initial count and expires again every K scans.
- R4: An expired entry without the repeat flag is retired and produces no further events.
- R5: An initial count of 0 means a period of 2^CNT_W scans (65536 with the default width).
- R6: A command with enable = 0 retires the addressed entry. A retired entry is skipped and raises no event. Such a command also stops a running repeating timer.
- R7: A command accepted while the engine is idle is written at once and first counted by the next scan. A command that arrives during a scan is held, with `cmd_busy` = 1 from the next clock. It is written after the scan completes and before the next scan starts, and `cmd_busy` then returns to 0.
- R8: A command presented while `cmd_busy` = 1 is discarded.
- R9: An event bit stays set until the host writes 1 to the same bit of `ev_clr`. Writing a bit clears only that bit.
- R10: If an expiry and an `ev_clr` write hit the same bit in the same clock, the bit ends set.
- R11: `irq` is 1 exactly when some bit is set in both `events` and `irq_mask`.
- R12: A tick that arrives while a scan is in progress is dropped and sets the sticky `overrun` flag. Only reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_period | input | PRE_W | Clocks per tick |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_idx | input | IDX_W | Timer index addressed by the command |
| cmd_init | input | CNT_W | Initial count, 0 meaning 2^CNT_W |
| cmd_restart | input | 1 | Repeat flag for the entry |
| cmd_enable | input | 1 | 1 arms the entry, 0 retires it |
| cmd_busy | output | 1 | A command is held waiting for the scan to finish |
| ev_clr | input | N_TIMERS | Write-one-to-clear strobes for the event bits |
| irq_mask | input | N_TIMERS | Interrupt enable per timer |
| events | output | N_TIMERS | Expiry event bits |
| irq | output | 1 | Masked OR of the event bits |
| tick_count | output | 16 | Count of completed scans |
| overrun | output | 1 | Sticky flag for a tick lost during a scan |

## Verification
The bench places a command in the middle of a scan for an entry the scan has not reached yet. An engine that wrote the entry at once would fire one scan early. A command presented while the holding register is full would show up as an extra event. One test holds a clear on a bit through its expiry clock, so a clear that won the tie would hide the event completely. A zero initial count is run to the full period to catch a design that treats it as "expire now" or as a one-tick period. With the tick faster than a scan, a design that did not drop the extra tick would show a shorter tick-counter spacing or a missing overrun flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TICK_CNT_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } scan_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] period,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = (period == '0) ? '0 : period - 1'b1;
        tick  = (cnt_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tmr_table_ram.sv
module tmr_table_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 18,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tmr_scan_engine.sv
module tmr_scan_engine import tmr_pkg::*; #(
    parameter int N_TIMERS = 16,
    parameter int CNT_W    = 16,
    parameter int IDX_W    = 4,
    parameter int ENT_W    = 2 + 2 * CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [ENT_W-1:0]    rd_entry,
    output logic [IDX_W-1:0]    idx,
    output logic                wr_en,
    output logic [ENT_W-1:0]    wr_data,
    output logic [N_TIMERS-1:0] ev_set,
    output logic                idle,
    output logic                done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_TIMERS - 1);

    scan_state_e      state_q;
    logic [IDX_W-1:0] idx_q;

    logic             e_valid;
    logic             e_restart;
    logic [CNT_W-1:0] e_init;
    logic [CNT_W-1:0] e_cur;
    logic [CNT_W-1:0] e_next;
    logic             expired;
    logic             scanning;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (tick) state_q <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= ST_FINISH;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        scanning  = (state_q == ST_SCAN);
        e_valid   = rd_entry[ENT_W-1];
        e_restart = rd_entry[ENT_W-2];
        e_init    = rd_entry[2*CNT_W-1 -: CNT_W];
        e_cur     = rd_entry[CNT_W-1:0];
        e_next    = e_cur - 1'b1;
        expired   = (e_next == '0);

        if (!expired)
            wr_data = {e_valid, e_restart, e_init, e_next};
        else if (e_restart)
            wr_data = {1'b1, 1'b1, e_init, e_init};
        else
            wr_data = {1'b0, 1'b0, e_init, {CNT_W{1'b0}}};

        wr_en  = scanning && e_valid;
        ev_set = '0;
        if (scanning && e_valid && expired) ev_set[idx_q] = 1'b1;

        idx  = idx_q;
        idle = (state_q == ST_IDLE);
        done = (state_q == ST_FINISH);
    end
endmodule

// File: rtl/tmr_event_reg.sv
module tmr_event_reg #(
    parameter int N_TIMERS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_TIMERS-1:0] set,
    input  logic [N_TIMERS-1:0] clr,
    input  logic [N_TIMERS-1:0] mask,
    output logic [N_TIMERS-1:0] bits,
    output logic                irq
);
    logic [N_TIMERS-1:0] bits_q;

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         bits_q[g] <= 1'b0;
            else if (set[g]) bits_q[g] <= 1'b1;
            else if (clr[g]) bits_q[g] <= 1'b0;
        end
    end

    assign bits = bits_q;
    assign irq  = |(bits_q & mask);
endmodule

// File: rtl/tmr_table_top.sv
module tmr_table_top import tmr_pkg::*; #(
    parameter int N_TIMERS = 16,
    parameter int CNT_W    = 16,
    parameter int PRE_W    = 16,
    localparam int IDX_W   = idx_width(N_TIMERS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PRE_W-1:0]      tick_period,
    input  logic                  cmd_valid,
    input  logic [IDX_W-1:0]      cmd_idx,
    input  logic [CNT_W-1:0]      cmd_init,
    input  logic                  cmd_restart,
    input  logic                  cmd_enable,
    output logic                  cmd_busy,
    input  logic [N_TIMERS-1:0]   ev_clr,
    input  logic [N_TIMERS-1:0]   irq_mask,
    output logic [N_TIMERS-1:0]   events,
    output logic                  irq,
    output logic [TICK_CNT_W-1:0] tick_count,
    output logic                  overrun
);
    localparam int ENT_W = 2 + 2 * CNT_W;

    logic                tick_w;
    logic [IDX_W-1:0]    eng_idx;
    logic                eng_we;
    logic [ENT_W-1:0]    eng_wdata;
    logic [ENT_W-1:0]    rd_entry;
    logic [N_TIMERS-1:0] eng_set;
    logic                eng_idle;
    logic                eng_done;

    logic                pend_q;
    logic [IDX_W-1:0]    pend_idx_q;
    logic [CNT_W-1:0]    pend_init_q;
    logic                pend_rst_q;
    logic                pend_en_q;

    logic                accept;
    logic                cmd_direct;
    logic                pend_apply;
    logic                ram_we;
    logic [IDX_W-1:0]    ram_waddr;
    logic [ENT_W-1:0]    ram_wdata;
    logic [ENT_W-1:0]    cmd_wdata;

    logic [TICK_CNT_W-1:0] tcnt_q;
    logic                  ovr_q;

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .period (tick_period),
        .tick   (tick_w)
    );

    tmr_scan_engine #(
        .N_TIMERS (N_TIMERS),
        .CNT_W    (CNT_W),
        .IDX_W    (IDX_W),
        .ENT_W    (ENT_W)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_w),
        .rd_entry (rd_entry),
        .idx      (eng_idx),
        .wr_en    (eng_we),
        .wr_data  (eng_wdata),
        .ev_set   (eng_set),
        .idle     (eng_idle),
        .done     (eng_done)
    );

    // Command path: direct write when idle, otherwise park in holding register
    always_comb begin
        accept     = cmd_valid && !pend_q;
        cmd_direct = accept && eng_idle;
        pend_apply = pend_q && eng_idle;
        if (pend_apply)
            cmd_wdata = {pend_en_q, pend_rst_q, pend_init_q, pend_init_q};
        else
            cmd_wdata = {cmd_enable, cmd_restart, cmd_init, cmd_init};
        ram_we    = eng_we || cmd_direct || pend_apply;
        ram_waddr = eng_we ? eng_idx : (pend_apply ? pend_idx_q : cmd_idx);
        ram_wdata = eng_we ? eng_wdata : cmd_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            pend_idx_q  <= '0;
            pend_init_q <= '0;
            pend_rst_q  <= 1'b0;
            pend_en_q   <= 1'b0;
        end else if (accept && !eng_idle) begin
            pend_q      <= 1'b1;
            pend_idx_q  <= cmd_idx;
            pend_init_q <= cmd_init;
            pend_rst_q  <= cmd_restart;
            pend_en_q   <= cmd_enable;
        end else if (pend_apply) begin
            pend_q      <= 1'b0;
        end
    end

    tmr_table_ram #(
        .DEPTH (N_TIMERS),
        .WIDTH (ENT_W),
        .AW    (IDX_W)
    ) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (eng_idx),
        .rdata (rd_entry)
    );

    tmr_event_reg #(.N_TIMERS(N_TIMERS)) u_evt (
        .clk  (clk),
        .rst  (rst),
        .set  (eng_set),
        .clr  (ev_clr),
        .mask (irq_mask),
        .bits (events),
        .irq  (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (eng_done)           tcnt_q <= tcnt_q + 1'b1;
            if (tick_w && !eng_idle) ovr_q <= 1'b1;
        end
    end

    assign cmd_busy   = pend_q;
    assign tick_count = tcnt_q;
    assign overrun    = ovr_q;
endmodule

// File: rtl/tmr_table_chk.sv
module tmr_table_chk #(
    parameter int N_TIMERS = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_valid,
    input logic                cmd_busy,
    input logic [N_TIMERS-1:0] ev_clr,
    input logic [N_TIMERS-1:0] events,
    input logic                irq,
    input logic [15:0]         tick_count,
    input logic                overrun,
    input logic                tick,
    input logic                eng_idle,
    input logic [N_TIMERS-1:0] eng_set
);
    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (tick_count != $past(tick_count)) |-> (tick_count == $past(tick_count) + 16'd1));

    p_busy_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_busy) |-> ($past(cmd_valid) && !$past(eng_idle)));

    p_busy_drain_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_busy && eng_idle) |=> !cmd_busy);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_busy && !eng_idle) |=> cmd_busy);

    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (events == '0) |-> !irq);

    p_ovr_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        $past(overrun) |-> overrun);

    p_ovr_cause_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> ($past(tick) && !$past(eng_idle)));

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_evchk
        p_event_src_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(events[g]) |-> $past(eng_set[g]));

        p_event_hold_r9: assert property (@(posedge clk) disable iff (rst)
            $fell(events[g]) |-> $past(ev_clr[g]));

        p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
            $past(eng_set[g]) |-> events[g]);
    end
endmodule

bind tmr_table_top tmr_table_chk #(.N_TIMERS(N_TIMERS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_busy   (cmd_busy),
    .ev_clr     (ev_clr),
    .events     (events),
    .irq        (irq),
    .tick_count (tick_count),
    .overrun    (overrun),
    .tick       (tick_w),
    .eng_idle   (eng_idle),
    .eng_set    (eng_set)
);

// File: tb/tb_tmr_table_top.sv
module tb_tmr_table_top;
    localparam int N  = 16;
    localparam int CW = 8;
    localparam int PW = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] tick_period = 16'd24;
    logic          cmd_valid = 1'b0;
    logic [IW-1:0] cmd_idx = '0;
    logic [CW-1:0] cmd_init = '0;
    logic          cmd_restart = 1'b0;
    logic          cmd_enable = 1'b0;
    logic          cmd_busy;
    logic [N-1:0]  ev_clr;
    logic [N-1:0]  irq_mask = '0;
    logic [N-1:0]  events;
    logic          irq;
    logic [15:0]   tick_count;
    logic          overrun;

    logic [N-1:0]  mon_clr = '0;
    logic [N-1:0]  tst_clr = '0;
    logic          auto_clr = 1'b1;
    assign ev_clr = mon_clr | tst_clr;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R2";

    typedef struct { int idx; int cnt; } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;

    tmr_table_top #(.N_TIMERS(N), .CNT_W(CW), .PRE_W(PW)) dut (
        .clk(clk), .rst(rst), .tick_period(tick_period),
        .cmd_valid(cmd_valid), .cmd_idx(cmd_idx), .cmd_init(cmd_init),
        .cmd_restart(cmd_restart), .cmd_enable(cmd_enable), .cmd_busy(cmd_busy),
        .ev_clr(ev_clr), .irq_mask(irq_mask), .events(events), .irq(irq),
        .tick_count(tick_count), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push_exp(input int idx, input int cnt);
        exp_t e;
        e.idx = idx;
        e.cnt = cnt;
        sbq.push_back(e);
    endtask

    // Monitor: every newly set event bit must match one expected item
    initial begin
        logic [N-1:0] prev;
        logic [N-1:0] nw;
        prev = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev    = '0;
                mon_clr = '0;
            end else begin
                nw = events & ~prev;
                for (int i = 0; i < N; i++) begin
                    if (nw[i]) begin
                        int hit;
                        hit = -1;
                        for (int k = 0; k < sbq.size(); k++)
                            if (hit < 0 && sbq[k].idx == i && sbq[k].cnt == int'(tick_count)) hit = k;
                        checks++;
                        if (hit >= 0) sbq.delete(hit);
                        else begin
                            errors++;
                            $display("FAIL %s: unexpected event timer %0d at count %0d (actual) expected none",
                                     cur_tag, i, tick_count);
                        end
                    end
                end
                prev    = events;
                mon_clr = auto_clr ? nw : '0;
            end
        end
    end

    task automatic sb_empty(input string tag);
        chk(sbq.size() == 0, tag, sbq.size(), 0);
        sbq.delete();
    endtask

    task automatic wait_scan();
        logic [15:0] c;
        c = tick_count;
        while (tick_count == c) @(negedge clk);
    endtask

    task automatic run_scans(input int n);
        for (int i = 0; i < n; i++) wait_scan();
    endtask

    task automatic set_timer(input int idx, input int init, input bit rs, input bit en);
        cmd_valid   = 1'b1;
        cmd_idx     = IW'(idx);
        cmd_init    = CW'(init);
        cmd_restart = rs;
        cmd_enable  = en;
        @(negedge clk);
        cmd_valid   = 1'b0;
    endtask

    task automatic measure(output int n);
        logic [15:0] c;
        wait_scan();
        c = tick_count;
        n = 0;
        while (tick_count == c) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c;
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        chk(tick_count == 0, "R1 reset tick_count", tick_count, 0);
        chk(events == '0, "R9 reset events", events, 0);
        chk(!irq, "R11 reset irq", irq, 0);
        chk(!cmd_busy, "R7 reset busy", cmd_busy, 0);
        chk(!overrun, "R12 reset overrun", overrun, 0);

        // R2 / R4 / R7: one-shot timer programmed in idle window
        cur_tag = "R4";
        wait_scan();
        c = tick_count;
        set_timer(3, 3, 1'b0, 1'b1);
        push_exp(3, c + 2);
        run_scans(6);
        sb_empty("R4 one-shot fires once");

        // R3 repeating timer, then R6 stop it
        cur_tag = "R3";
        wait_scan();
        c = tick_count;
        set_timer(7, 2, 1'b1, 1'b1);
        push_exp(7, c + 1);
        push_exp(7, c + 3);
        push_exp(7, c + 5);
        run_scans(6);
        sb_empty("R3 repeat every 2 scans");
        cur_tag = "R6";
        set_timer(7, 0, 1'b0, 1'b0);
        set_timer(9, 1, 1'b1, 1'b0);
        run_scans(5);
        sb_empty("R6 disabled entries silent");

        // R2 several timers expiring in one scan
        cur_tag = "R2";
        wait_scan();
        c = tick_count;
        set_timer(0, 1, 1'b0, 1'b1);
        set_timer(15, 1, 1'b0, 1'b1);
        set_timer(4, 1, 1'b0, 1'b1);
        push_exp(0, c);
        push_exp(15, c);
        push_exp(4, c);
        run_scans(3);
        sb_empty("R2 same-scan expiries");

        // R7 / R8: command during a scan is held; a second one is discarded
        cur_tag = "R8";
        wait_scan();
        c = tick_count;
        repeat (10) @(negedge clk);
        cmd_valid = 1'b1; cmd_idx = 4'd12; cmd_init = 8'd1; cmd_restart = 1'b0; cmd_enable = 1'b1;
        @(negedge clk);
        chk(cmd_busy, "R7 busy while held", cmd_busy, 1);
        cmd_idx = 4'd5; cmd_init = 8'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        push_exp(12, c + 1);
        wait_scan();
        @(negedge clk);
        chk(!cmd_busy, "R7 busy released after scan", cmd_busy, 0);
        run_scans(3);
        sb_empty("R7 held command timing, R8 discard");

        // R9 / R11: sticky events, per-bit clear, masked interrupt
        cur_tag = "R9";
        auto_clr = 1'b0;
        wait_scan();
        c = tick_count;
        set_timer(5, 1, 1'b0, 1'b1);
        set_timer(6, 1, 1'b0, 1'b1);
        push_exp(5, c);
        push_exp(6, c);
        run_scans(2);
        chk(events == 16'h0060, "R9 events stay set", events, 16'h0060);
        irq_mask = 16'h0020;
        @(negedge clk);
        chk(irq, "R11 irq with mask on set bit", irq, 1);
        irq_mask = 16'h0100;
        @(negedge clk);
        chk(!irq, "R11 irq masked", irq, 0);
        tst_clr = 16'h0020;
        @(negedge clk);
        tst_clr = '0;
        chk(events == 16'h0040, "R9 clear one bit", events, 16'h0040);
        irq_mask = 16'h0020;
        @(negedge clk);
        chk(!irq, "R11 irq after clear", irq, 0);
        irq_mask = 16'h0040;
        @(negedge clk);
        chk(irq, "R11 irq other bit", irq, 1);
        tst_clr = 16'h0040;
        @(negedge clk);
        tst_clr = '0;
        chk(events == '0, "R9 all cleared", events, 0);
        irq_mask = '0;
        auto_clr = 1'b1;
        sb_empty("R9 events seen");

        // R10: clear held on a bit through its expiry clock
        cur_tag = "R10";
        tst_clr = 16'h0400;
        wait_scan();
        c = tick_count;
        set_timer(10, 2, 1'b0, 1'b1);
        push_exp(10, c + 1);
        run_scans(3);
        tst_clr = '0;
        sb_empty("R10 expiry beats clear");

        // R5: zero initial count gives 2^CW scans
        cur_tag = "R5";
        wait_scan();
        c = tick_count;
        set_timer(1, 0, 1'b0, 1'b1);
        push_exp(1, c + 255);
        run_scans(258);
        sb_empty("R5 zero count full period");

        // R1 tick spacing
        measure(n);
        chk(n == 24, "R1 period 24", n, 24);
        chk(!overrun, "R12 no overrun at slow tick", overrun, 0);
        tick_period = 16'd16384;
        wait_scan();
        measure(n);
        chk(n == 16384, "R1 period 16384", n, 16384);

        // R12 overrun: tick faster than a scan
        tick_period = 16'd10;
        wait_scan();
        measure(n);
        chk(n == 20, "R12 dropped tick spacing", n, 20);
        chk(overrun, "R12 overrun set", overrun, 1);
        repeat (30) @(negedge clk);
        chk(overrun, "R12 overrun sticky", overrun, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule